// File: doc/BRIEF.md
# Address Line Fault Detector

This engine checks the address lines that reach a word-wide memory for opens, stuck lines and shorts. It takes a region given as a byte base and a byte span. It picks a test address and walks a single set bit across the address. The bit starts at the position equal to the word size in bytes and moves up to the top address bit. At each position the engine forms a partner address that differs from the test address in that one line. It then checks whether the two locations are really distinct storage or the same cell seen twice.

A partner that lies outside the region is skipped. For a partner inside the region, the engine reads the partner and writes the complement of that value to the test address. It then reads the partner again. If the second read returns the complement, the write has reached the partner, and the two addresses alias.

The wrapper runs the walk twice. The first pass uses the region base as the test address, which walks a one through the address bits. The second pass uses the last 64-bit word of the region, which walks a zero. The second pass starts only if the first pass found no fault. The first fault stops the test and keeps the offending pair and mask.

Top module: `addr_line_checker`

## Requirements
- R1: The flip mask holds at most one set bit. Its first value equals the word size in bytes (4 for 32-bit words). After each step it moves up one bit, and the pass ends when the bit leaves the address width. Every read goes to the test address XOR the mask, an address that differs from the test address in exactly one bit.
- R2: A partner below the region base, or at or above base plus span, causes no memory access. Skipping it costs one cycle.
- R3: A partner inside the region takes exactly four cycles. In order: a read of the partner, a write of the bitwise complement of the returned word to the test address, a second read of the partner, and a compare cycle. Each pass therefore makes two reads and one write per in-range step.
- R4: A fault is reported when the second partner read equals the complement just written. `fail` then goes high with `done`. The capture outputs hold the test address, the partner address and the mask of that step, and no further steps run.
- R5: The first pass uses the region base as the test address. The second pass uses base + span - 8. The second pass runs only when the first pass has no fault.
- R6: `done` is high for exactly one cycle. Let N be the cycles of a pass: 4 per in-range step, 1 per skipped step, and 1 closing cycle when the mask runs out. `done` rises 1 + N0 clock edges after the edge that accepts `start` when pass one faults. It rises 2 + N0 + N1 edges after that edge when pass one is clean.
- R7: While a test runs, `start` is ignored. Changes to `region_base` and `region_size` have no effect on the test in progress.
- R8: After reset, `done`, `fail` and `mem_en` are low.
- R9: An accepted `start` clears `fail` and the capture outputs. They then hold their final values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a test when idle |
| region_base | input | ADDR_W | Byte address of the first word of the region |
| region_size | input | ADDR_W+1 | Region span in bytes |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | An address-line fault was found |
| fail_test_addr | output | ADDR_W | Test address of the faulting step |
| fail_partner_addr | output | ADDR_W | Partner address of the faulting step |
| fail_mask | output | ADDR_W | Flip mask of the faulting step |

## Verification
Read data is due in the cycle after each read request. `done`, `fail` and the capture outputs are due a fixed number of edges after the accepting edge, as given by the N0/N1 count in R6. A bench-side cycle counter restarts on the edge that accepts `start`. A bench-side access counter tallies reads and writes over the same window. The monitor samples on the falling edge and compares both counts with a model, so an extra, missing or late cycle shows up as a latency mismatch. Fault cases use a memory model with a stuck line or two bridged lines. The model predicts from address aliasing alone which pass and which mask must fail.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_PROBE,
    WK_FLIP,
    WK_REREAD,
    WK_JUDGE
  } walk_state_e;

  typedef enum logic {
    SQ_IDLE,
    SQ_RUN
  } seq_state_e;

endpackage

// File: rtl/alc_rst_sync.sv
module alc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/alc_pair_gen.sv
module alc_pair_gen #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] test_addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W:0]   span,
  output logic [ADDR_W-1:0] partner_addr,
  output logic              in_range
);

  logic [ADDR_W:0] partner_ext;
  logic [ADDR_W:0] base_ext;
  logic [ADDR_W:0] limit_ext;

  assign partner_addr = test_addr ^ mask;
  assign partner_ext  = {1'b0, partner_addr};
  assign base_ext     = {1'b0, base_addr};
  assign limit_ext    = base_ext + span;
  assign in_range     = (partner_ext >= base_ext) && (partner_ext < limit_ext);

endmodule

// File: rtl/alc_walker.sv
module alc_walker
  import alc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] test_addr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W:0]   span,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fin,
  output logic              fault,
  output logic [ADDR_W-1:0] partner_addr,
  output logic [ADDR_W-1:0] cur_mask
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] FIRST_MASK = ADDR_W'(WORD_BYTES);

  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] mask_q, mask_d;
  logic              mask_en;
  logic [DATA_W-1:0] comp_q, comp_d;
  logic              comp_en;
  logic              in_range;

  alc_pair_gen #(.ADDR_W(ADDR_W)) u_pair (
    .test_addr   (test_addr),
    .mask        (mask_q),
    .base_addr   (base_addr),
    .span        (span),
    .partner_addr(partner_addr),
    .in_range    (in_range)
  );

  always_comb begin
    st_d      = st_q;
    mask_d    = mask_q;
    mask_en   = 1'b0;
    comp_d    = comp_q;
    comp_en   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = partner_addr;
    mem_wdata = '0;
    fin       = 1'b0;
    fault     = 1'b0;
    case (st_q)
      WK_IDLE: begin
        if (go) begin
          st_d    = WK_PROBE;
          mask_d  = FIRST_MASK;
          mask_en = 1'b1;
        end
      end
      WK_PROBE: begin
        if (mask_q == '0) begin
          fin  = 1'b1;
          st_d = WK_IDLE;
        end else if (in_range) begin
          mem_en = 1'b1;
          st_d   = WK_FLIP;
        end else begin
          mask_d  = mask_q << 1;
          mask_en = 1'b1;
        end
      end
      WK_FLIP: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = test_addr;
        mem_wdata = ~mem_rdata;
        comp_d    = ~mem_rdata;
        comp_en   = 1'b1;
        st_d      = WK_REREAD;
      end
      WK_REREAD: begin
        mem_en = 1'b1;
        st_d   = WK_JUDGE;
      end
      WK_JUDGE: begin
        if (mem_rdata == comp_q) begin
          fin   = 1'b1;
          fault = 1'b1;
          st_d  = WK_IDLE;
        end else begin
          mask_d  = mask_q << 1;
          mask_en = 1'b1;
          st_d    = WK_PROBE;
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      mask_q <= '0;
      comp_q <= '0;
    end else begin
      st_q <= st_d;
      if (mask_en) mask_q <= mask_d;
      if (comp_en) comp_q <= comp_d;
    end
  end

  assign cur_mask = mask_q;

  assert_mask_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));

  assert_read_one_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> ($countones(mem_addr ^ test_addr) == 1));

  assert_read_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |->
      (({1'b0, mem_addr} >= {1'b0, base_addr}) &&
       ({1'b0, mem_addr} < ({1'b0, base_addr} + span))));

  assert_write_to_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == test_addr));

  assert_reread_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (mem_en && !mem_we));

endmodule

// File: rtl/addr_line_checker.sv
module addr_line_checker
  import alc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int TAIL_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [ADDR_W:0]   region_size,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_test_addr,
  output logic [ADDR_W-1:0] fail_partner_addr,
  output logic [ADDR_W-1:0] fail_mask
);

  localparam logic [ADDR_W-1:0] TAIL_OFS = ADDR_W'(TAIL_BYTES);

  logic              rst_n_i;
  seq_state_e        sq_q, sq_d;
  logic              pass_q, pass_d;
  logic              go_q, go_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic              accept;
  logic              cap_load;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W:0]   span_q;
  logic [ADDR_W-1:0] tail_addr;
  logic [ADDR_W-1:0] test_addr;
  logic [ADDR_W-1:0] cap_test_q, cap_part_q, cap_mask_q;
  logic              w_fin, w_fault;
  logic [ADDR_W-1:0] w_partner, w_mask;

  alc_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_i)
  );

  assign tail_addr = base_q + span_q[ADDR_W-1:0] - TAIL_OFS;
  assign test_addr = pass_q ? tail_addr : base_q;

  alc_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .go          (go_q),
    .test_addr   (test_addr),
    .base_addr   (base_q),
    .span        (span_q),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .fin         (w_fin),
    .fault       (w_fault),
    .partner_addr(w_partner),
    .cur_mask    (w_mask)
  );

  always_comb begin
    sq_d     = sq_q;
    pass_d   = pass_q;
    go_d     = 1'b0;
    done_d   = 1'b0;
    fail_d   = fail_q;
    accept   = 1'b0;
    cap_load = 1'b0;
    case (sq_q)
      SQ_IDLE: begin
        if (start) begin
          accept = 1'b1;
          sq_d   = SQ_RUN;
          pass_d = 1'b0;
          go_d   = 1'b1;
          fail_d = 1'b0;
        end
      end
      SQ_RUN: begin
        if (w_fin) begin
          if (w_fault) begin
            fail_d   = 1'b1;
            done_d   = 1'b1;
            cap_load = 1'b1;
            sq_d     = SQ_IDLE;
          end else if (!pass_q) begin
            pass_d = 1'b1;
            go_d   = 1'b1;
          end else begin
            done_d = 1'b1;
            sq_d   = SQ_IDLE;
          end
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sq_q       <= SQ_IDLE;
      pass_q     <= 1'b0;
      go_q       <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      base_q     <= '0;
      span_q     <= '0;
      cap_test_q <= '0;
      cap_part_q <= '0;
      cap_mask_q <= '0;
    end else begin
      sq_q   <= sq_d;
      pass_q <= pass_d;
      go_q   <= go_d;
      done_q <= done_d;
      fail_q <= fail_d;
      if (accept) begin
        base_q <= region_base;
        span_q <= region_size;
      end
      if (accept) begin
        cap_test_q <= '0;
        cap_part_q <= '0;
        cap_mask_q <= '0;
      end else if (cap_load) begin
        cap_test_q <= test_addr;
        cap_part_q <= w_partner;
        cap_mask_q <= w_mask;
      end
    end
  end

  assign done              = done_q;
  assign fail              = fail_q;
  assign fail_test_addr    = cap_test_q;
  assign fail_partner_addr = cap_part_q;
  assign fail_mask         = cap_mask_q;

  assert_fail_rises_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(fail_q) |-> done_q);

  assert_second_pass_clean_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(pass_q) |-> !fail_q);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    done_q |=> !done_q);

  assert_region_held_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sq_q == SQ_RUN) |=> ($stable(base_q) && $stable(span_q)));

endmodule

// File: tb/sim_addr_line_checker.sv
`timescale 1ns/1ps
module sim_addr_line_checker;

  localparam int AW = 12;
  localparam int DW = 32;

  typedef struct packed {
    logic        fail;
    logic [31:0] test;
    logic [31:0] partner;
    logic [31:0] mask;
    logic [31:0] lat;
    logic [31:0] rd;
    logic [31:0] wr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] region_base = '0;
  logic [AW:0]   region_size = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          done, fail;
  logic [AW-1:0] fail_test_addr, fail_partner_addr, fail_mask;

  logic [DW-1:0] mem [0:(1<<(AW-2))-1];
  int            fault_mode = 0;
  int            fault_bit  = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            busy_exp = 1'b0;
  bit            finished = 1'b0;
  int            cyc = 0;
  int            nrd = 0;
  int            nwr = 0;
  exp_t          q[$];
  exp_t          got;

  always #2 clk = ~clk;

  addr_line_checker #(.ADDR_W(AW), .DATA_W(DW), .TAIL_BYTES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .region_base(region_base), .region_size(region_size),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_test_addr(fail_test_addr),
    .fail_partner_addr(fail_partner_addr), .fail_mask(fail_mask)
  );

  // Physical word reached by a byte address under the injected wiring fault.
  function automatic int phys(int a, int mode, int k);
    int b;
    if (mode == 1) return a & ~(1 << k);
    if (mode == 2) begin
      b = ((a >> k) & 1) | ((a >> (k + 1)) & 1);
      return (a & ~(3 << k)) | (b << k) | (b << (k + 1));
    end
    return a;
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[phys(int'(mem_addr), fault_mode, fault_bit) >> 2] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[phys(int'(mem_addr), fault_mode, fault_bit) >> 2];
  end

  always @(posedge clk) begin
    if (start && !busy_exp) begin
      cyc <= 0; nrd <= 0; nwr <= 0;
    end else begin
      cyc <= cyc + 1;
      if (mem_en && !mem_we) nrd <= nrd + 1;
      if (mem_en && mem_we)  nwr <= nwr + 1;
    end
  end

  function automatic exp_t model(int base, int size, int mode, int k);
    exp_t e;
    int t, pt, n;
    e = '0;
    e.lat = 1;
    for (int p = 0; p < 2; p++) begin
      if (p == 1) e.lat = e.lat + 1;
      t = (p == 0) ? base : base + size - 8;
      n = 0;
      for (int m = 4; m < (1 << AW); m = m << 1) begin
        pt = t ^ m;
        if (pt >= base && pt < base + size) begin
          n = n + 4;
          e.rd = e.rd + 2;
          e.wr = e.wr + 1;
          if (phys(t, mode, k) == phys(pt, mode, k)) begin
            e.fail = 1'b1; e.test = t; e.partner = pt; e.mask = m;
            e.lat = e.lat + n;
            return e;
          end
        end else begin
          n = n + 1;
        end
      end
      n = n + 1;
      e.lat = e.lat + n;
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the expected item when done shows up.
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R6", "done longer than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6", "unexpected done", 1, 0);
        end else begin
          got = q.pop_front();
          chk(cyc == int'(got.lat), "R6", "done latency", cyc, int'(got.lat));
          chk(fail == got.fail, "R4", "fail flag", int'(fail), int'(got.fail));
          chk(int'(fail_test_addr) == int'(got.test), "R5", "test address",
              int'(fail_test_addr), int'(got.test));
          chk(int'(fail_partner_addr) == int'(got.partner), "R1", "partner address",
              int'(fail_partner_addr), int'(got.partner));
          chk(int'(fail_mask) == int'(got.mask), "R1", "flip mask",
              int'(fail_mask), int'(got.mask));
          chk(nrd == int'(got.rd), "R3", "read count", nrd, int'(got.rd));
          chk(nwr == int'(got.wr), "R2", "write count", nwr, int'(got.wr));
        end
        busy_exp = 1'b0;
      end
      prev_done = done;
    end
  end

  // Driver: pushes the expected outcome, then starts the test.
  task automatic run(input int base, input int size, input int mode,
                     input int k, input bit poke);
    exp_t e;
    e = model(base, size, mode, k);
    q.push_back(e);
    fault_mode  = mode;
    fault_bit   = k;
    region_base = AW'(base);
    region_size = (AW+1)'(size);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    #1 busy_exp = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start       = 1'b1;
      region_base = AW'(base ^ 'h40);
      region_size = (AW+1)'(size >> 1);
      @(negedge clk) start = 1'b0;
    end
    while (busy_exp) @(negedge clk);
    repeat (3) @(negedge clk);
    // R9: results hold after done
    chk(fail == e.fail, "R9", "fail held", int'(fail), int'(e.fail));
    chk(int'(fail_mask) == int'(e.mask), "R9", "mask held", int'(fail_mask), int'(e.mask));
    chk(done == 1'b0, "R6", "done low after pulse", int'(done), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(done == 1'b0, "R8", "done after reset", int'(done), 0);
    chk(fail == 1'b0, "R8", "fail after reset", int'(fail), 0);
    chk(mem_en == 1'b0, "R8", "mem_en after reset", int'(mem_en), 0);
    run(0, 'h1000, 0, 0, 0);      // R1 R3 R5: full space, clean
    run('h100, 'h100, 0, 0, 0);   // R2: many partners skipped
    run('h300, 'h500, 0, 0, 0);   // R2: non-zero, non-aligned region
    run(0, 'h800, 1, 11, 0);      // R2: stuck line outside the region
    run(0, 'h1000, 1, 5, 0);      // R4: stuck-at-zero line, first pass
    run('h100, 'h100, 2, 2, 0);   // R5: bridged lines, second pass
    run(0, 'h1000, 0, 0, 1);      // R7 and R9: ignored restart, fail cleared
    chk(q.size() == 0, "R6", "missing done", q.size(), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog expired: actual timeout expected done");
    summary();
  end

endmodule